// File: doc/BRIEF.md
# Peripheral Error Interrupt Aggregator

This block folds the error indications of eight peripherals into one shared error interrupt. It also resolves which peripheral a given service pass belongs to. The eight sources are:

| ID | Source |
|----|--------|
| 0 | Ethernet MAC |
| 1 | Serial port 0 |
| 2 | Serial port 1 |
| 3 | Parallel port |
| 4 | CAN controller |
| 5 | SPI |
| 6 | UART0 |
| 7 | UART1 |

Six of the sources report errors through a single flag. Each UART reports through two status conditions, and a UART error counts only when both conditions are true together.

Each source has an enable bit. The enables decide whether the upstream interrupt line is open at all. When the line is serviced, the enables also decide what happens to the selected error.

When the interrupt controller signals a service pass on `eval_i`, the block evaluates the current errors and picks exactly one source by fixed priority (lowest ID first). One cycle later it reports one of these outcomes:

- **Forward:** the winner is enabled, so the block raises a sub-interrupt carrying the winner's ID.
- **Clear:** the winner is a single-flag source and is disabled, so the block pulses that source's write-one-to-clear strobe.
- **Drop:** the winner is a disabled UART, which has no clear strobe, so the block does nothing.
- **No source:** no source holds an error, so the block raises the no-source diagnostic flag.

Top module: `err_agg`

## Requirements
- R1: Sources are ranked by ID 0 to 7 in the order MAC, serial port 0, serial port 1, parallel port, CAN, SPI, UART0, UART1. The lowest-ID source with an error wins, and at most one source is handled per evaluation.
- R2: UART u (ID 6+u) counts as erroring only when `uart_cond_a_i[u]` and `uart_cond_b_i[u]` are both 1. Either condition alone is ignored.
- R3: When `eval_i` is 1 in cycle N and the winner's bit in `src_en_i` is 1, then in cycle N+1 `sub_irq_o` is 1 and `sub_id_o` equals the winner's ID. In every other cycle `sub_id_o` is 0.
- R4: When `eval_i` is 1 in cycle N and the winner has ID 0 to 5 with its enable bit 0, then in cycle N+1 `clr_o` has exactly bit ID set and `sub_irq_o` is 0.
- R5: When `eval_i` is 1 and the winner is a UART whose enable bit is 0, the next cycle shows `sub_irq_o`, `clr_o` and `none_o` all 0.
- R6: When `eval_i` is 1 in cycle N and no source has an error, `none_o` is 1 in cycle N+1.
- R7: `line_en_o` is 1 exactly when any bit of `src_en_i` is 1. It is combinational.
- R8: When `eval_i` was 0 in the previous cycle, `sub_irq_o`, `clr_o` and `none_o` are all 0.
- R9: While `rst` is 1, the registered outputs are 0 at the next edge.
- R10: `share_irq_o` is 1 exactly when `line_en_o` is 1 and at least one source has an error. It is combinational.
- R11: In any cycle, at most one of the three outcomes (forward, clear, none) is shown, and `clr_o` is one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Service pass request from the interrupt controller |
| plain_err_i | input | 6 | Error flags of sources 0 to 5 |
| uart_cond_a_i | input | 2 | First error-status condition of each UART |
| uart_cond_b_i | input | 2 | Second error-status condition of each UART |
| src_en_i | input | 8 | Per-source enable, bit = source ID |
| share_irq_o | output | 1 | Combined error interrupt |
| line_en_o | output | 1 | Upstream line unmask |
| sub_irq_o | output | 1 | Forwarded sub-interrupt pulse |
| sub_id_o | output | 3 | ID of the forwarded source |
| clr_o | output | 6 | Write-one-to-clear strobes for sources 0 to 5 |
| none_o | output | 1 | Service pass found no source |

## Verification
A wrong priority scan or UART qualification shows up as a wrong `sub_id_o`, or as a strobe on the wrong `clr_o` bit, exactly one cycle after `eval_i`. A stale or mis-reset outcome register shows up as a pulse in the cycle after an idle `eval_i`. The bench sweeps all 1024 error patterns against sixteen enable masks. This covers every winner in both enable states, every partial UART condition, and the no-source case. Each outcome and the following idle cycle are compared.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;
    localparam int NUM_PLAIN = 6;
    localparam int NUM_UART  = 2;
    localparam int NUM_SRC   = NUM_PLAIN + NUM_UART;
    localparam int ID_W      = $clog2(NUM_SRC);

    typedef logic [ID_W-1:0]      src_id_t;
    typedef logic [NUM_SRC-1:0]   src_vec_t;
    typedef logic [NUM_PLAIN-1:0] plain_vec_t;

    typedef struct packed {
        logic       fwd;
        src_id_t    id;
        plain_vec_t clr;
        logic       none;
    } verdict_t;

    // Lowest set index wins; 0 if nothing set.
    function automatic src_id_t first_set(input src_vec_t v);
        src_id_t r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = src_id_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/err_agg_detect.sv
module err_agg_detect
    import err_agg_pkg::*;
(
    input  plain_vec_t          plain_err_i,
    input  logic [NUM_UART-1:0] cond_a_i,
    input  logic [NUM_UART-1:0] cond_b_i,
    output src_vec_t            det_o
);
    assign det_o[NUM_PLAIN-1:0] = plain_err_i;

    for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
        assign det_o[NUM_PLAIN+u] = cond_a_i[u] & cond_b_i[u];
    end
endmodule

// File: rtl/err_agg_pick.sv
module err_agg_pick
    import err_agg_pkg::*;
(
    input  logic     eval_i,
    input  src_vec_t det_i,
    input  src_vec_t en_i,
    output verdict_t next_o
);
    src_id_t win;
    logic    any_err;
    logic    win_en;
    logic    win_plain;

    always_comb begin
        any_err   = |det_i;
        win       = first_set(det_i);
        win_en    = en_i[win];
        win_plain = (int'(win) < NUM_PLAIN);

        next_o      = '0;
        next_o.none = eval_i & ~any_err;
        next_o.fwd  = eval_i & any_err & win_en;
        next_o.id   = (eval_i & any_err & win_en) ? win : '0;
        for (int i = 0; i < NUM_PLAIN; i++) begin
            next_o.clr[i] = eval_i & any_err & ~win_en & win_plain & (int'(win) == i);
        end
    end
endmodule

// File: rtl/err_agg.sv
module err_agg
    import err_agg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 eval_i,
    input  logic [NUM_PLAIN-1:0] plain_err_i,
    input  logic [NUM_UART-1:0]  uart_cond_a_i,
    input  logic [NUM_UART-1:0]  uart_cond_b_i,
    input  logic [NUM_SRC-1:0]   src_en_i,
    output logic                 share_irq_o,
    output logic                 line_en_o,
    output logic                 sub_irq_o,
    output logic [ID_W-1:0]      sub_id_o,
    output logic [NUM_PLAIN-1:0] clr_o,
    output logic                 none_o
);
    src_vec_t det;
    verdict_t nxt;
    verdict_t vq;

    err_agg_detect u_detect (
        .plain_err_i (plain_err_i),
        .cond_a_i    (uart_cond_a_i),
        .cond_b_i    (uart_cond_b_i),
        .det_o       (det)
    );

    err_agg_pick u_pick (
        .eval_i (eval_i),
        .det_i  (det),
        .en_i   (src_en_i),
        .next_o (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) vq <= '0;
        else     vq <= nxt;
    end

    assign line_en_o   = |src_en_i;
    assign share_irq_o = line_en_o & (|det);
    assign sub_irq_o   = vq.fwd;
    assign sub_id_o    = vq.id;
    assign clr_o       = vq.clr;
    assign none_o      = vq.none;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $countones({sub_irq_o, |clr_o, none_o}) <= 1);                     // R11
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_o));                                                  // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !eval_i |=> (!sub_irq_o && clr_o == '0 && !none_o));               // R8
    AST_FWD_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (eval_i && (|det)) |=> (sub_irq_o == (($past(src_en_i) >> sub_id_o) & 1'b1) || !sub_irq_o)); // R3
    AST_NONE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (eval_i && det == '0) |=> none_o);                                 // R6
    AST_ERR_NOT_NONE: assert property (@(posedge clk) disable iff (rst)
        (|det) |=> !none_o);                                               // R6
endmodule

// File: tb/sim_err_agg.sv
module sim_err_agg;
    logic       clk = 0;
    logic       rst = 1;
    logic       eval_i = 0;
    logic [5:0] plain_err_i = '0;
    logic [1:0] uart_cond_a_i = '0;
    logic [1:0] uart_cond_b_i = '0;
    logic [7:0] src_en_i = '0;
    logic       share_irq_o, line_en_o, sub_irq_o, none_o;
    logic [2:0] sub_id_o;
    logic [5:0] clr_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    err_agg u0 (
        .clk(clk), .rst(rst), .eval_i(eval_i), .plain_err_i(plain_err_i),
        .uart_cond_a_i(uart_cond_a_i), .uart_cond_b_i(uart_cond_b_i),
        .src_en_i(src_en_i), .share_irq_o(share_irq_o), .line_en_o(line_en_o),
        .sub_irq_o(sub_irq_o), .sub_id_o(sub_id_o), .clr_o(clr_o), .none_o(none_o)
    );

    task automatic cmp(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (err=%b/%b/%b en=%b)",
                     req, act, exp, plain_err_i, uart_cond_a_i, uart_cond_b_i, src_en_i);
        end
    endtask

    function automatic logic [7:0] en_pattern(input int k);
        logic [7:0] t [8] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h3F, 8'hC0};
        if (k < 8) return 8'(1 << k);
        return t[k-8];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: reset with stimulus that would otherwise produce an outcome
        @(negedge clk);
        eval_i = 1; plain_err_i = 6'h01; src_en_i = 8'h01;
        repeat (2) @(negedge clk);
        cmp("R9 sub_irq", int'(sub_irq_o), 0);
        cmp("R9 clr",     int'(clr_o), 0);
        cmp("R9 none",    int'(none_o), 0);
        cmp("R9 id",      int'(sub_id_o), 0);
        rst = 0; eval_i = 0;
        @(negedge clk);

        for (int k = 0; k < 16; k++) begin
            for (int v = 0; v < 1024; v++) begin
                logic [7:0] det, en;
                int  w;
                logic e_fwd, e_none;
                int  e_clr, e_id;
                en = en_pattern(k);
                plain_err_i   = v[5:0];
                uart_cond_a_i = v[7:6];
                uart_cond_b_i = v[9:8];
                src_en_i      = en;
                eval_i        = 1;
                det = {uart_cond_a_i & uart_cond_b_i, plain_err_i};
                w = 0;
                for (int i = 7; i >= 0; i--) if (det[i]) w = i;
                e_none = (det == 0);
                e_fwd  = (det != 0) && en[w];
                e_id   = e_fwd ? w : 0;
                e_clr  = ((det != 0) && !en[w] && w < 6) ? (1 << w) : 0;
                #1;
                cmp("R7 line_en", int'(line_en_o), int'(en != 0));
                cmp((v[9:6] != 0) ? "R10 R2 share_irq" : "R10 share_irq",
                    int'(share_irq_o), int'(en != 0 && det != 0));
                @(negedge clk);
                cmp((w >= 6) ? "R3 R2 fwd" : "R3 fwd", int'(sub_irq_o), int'(e_fwd));
                cmp("R1 id", int'(sub_id_o), e_id);
                cmp((w >= 6 && det != 0 && !en[w]) ? "R5 clr" : "R4 clr", int'(clr_o), e_clr);
                cmp("R6 none", int'(none_o), int'(e_none));
                cmp("R11 single outcome",
                    int'(sub_irq_o) + int'(clr_o != 0) + int'(none_o), int'(e_fwd) + int'(e_clr != 0) + int'(e_none));
                eval_i = 0;
                @(negedge clk);
                cmp("R8 idle", int'({sub_irq_o, clr_o, none_o}), 0);
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule